// File: doc/BRIEF.md
# Next-Program-Counter Resolver

This block decides where instruction fetch goes next in a 32-bit processor with byte addressing and four-byte instructions. Each cycle it receives the address of the current instruction, a decoded control-flow operation code, the two source register values, the 16-bit immediate and the 26-bit jump index of the instruction, and the register number a register-indirect call names. It returns the address of the following instruction, a flag saying the flow was redirected, and a write request that stores a return address into the register file for the two call forms.

The resolution path is purely combinational. A parameter adds a program-counter register that loads the resolved address on a rising edge whenever the step input is high, so the block can serve either as a bare next-address calculator or as the fetch pointer itself. Decode, the register file, delay slots and exceptions are left to the surrounding pipeline.

Top module: `npc_unit`

## Requirements
- R1: Operation codes 0 (sequential), 7 and 12 to 15 redirect nothing: `pc_next` equals `pc_in + 4` modulo 2^32 and `taken` is 0.
- R2: Code 1 is taken when `rs_val == rt_val`; code 2 is taken when they differ.
- R3: Codes 3, 4, 5 and 6 treat `rs_val` as a signed 32-bit two's-complement number and are taken when it is greater than zero, at least zero, below zero, and at most zero, respectively.
- R4: A taken conditional branch (codes 1 to 6) goes to `pc_in + 4 + 4*sext(imm16)`; an untaken one goes to `pc_in + 4`.
- R5: Codes 8 (absolute jump) and 10 (absolute call) are always taken and go to `{pc4[31:28], jidx, 2'b00}` where `pc4 = pc_in + 4`.
- R6: Codes 9 (register jump) and 11 (register call) are always taken and go to `rs_val`.
- R7: `link_we` is 1 only for codes 10 and 11, and is 0 for code 11 when `link_rd` is 0.
- R8: While `link_we` is 1, `link_data` equals `pc_in + 4`, and `link_idx` is 31 for code 10 or `link_rd` for code 11.
- R9: `taken` is 1 exactly when a conditional branch is satisfied or a jump or call code is applied; whenever `taken` is 0, `pc_next` equals `pc_in + 4`.
- R10: With the PC register present, a synchronous active-high `rst` at a rising edge sets `pc_q` to 0x00000000.
- R11: With the PC register present and `rst` low, `pc_q` takes the value of `pc_next` at a rising edge when `step` is 1 and keeps its value when `step` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the PC register |
| rst | input | 1 | Synchronous active-high reset of the PC register |
| step | input | 1 | Load enable of the PC register |
| pc_in | input | 32 | Address of the current instruction |
| op_sel | input | 4 | Decoded control-flow operation code |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| imm16 | input | 16 | Signed word offset of a conditional branch |
| jidx | input | 26 | Word index of an absolute jump or call |
| link_rd | input | 5 | Return-address register named by a register call |
| pc_next | output | 32 | Resolved address of the next instruction |
| taken | output | 1 | Control flow leaves the sequential path |
| link_we | output | 1 | Return-address write enable |
| link_idx | output | 5 | Return-address destination register |
| link_data | output | 32 | Return-address value |
| pc_q | output | 32 | Registered program counter |

## Verification
`pc_next`, `taken` and the three link outputs settle in the same cycle as their inputs, so the bench applies each operand combination and samples one nanosecond later, well away from any clock edge. `pc_q` changes only at a rising edge, one cycle after the step request, so the bench drives `step` and the operands after a falling edge and reads `pc_q` one nanosecond after the next rising edge. The combinational sweep covers all sixteen operation codes against wrap-around addresses, sign-boundary operands, both immediate signs and both zero and nonzero link registers.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN       = 32;
    localparam int IMM_W      = 16;
    localparam int IDX_W      = 26;
    localparam int RIDX_W     = 5;
    localparam int OP_W       = 4;
    localparam int INSN_BYTES = 4;
    localparam int ALIGN_W    = $clog2(INSN_BYTES);
    localparam int SEG_W      = XLEN - IDX_W - ALIGN_W;
    localparam int RET_REG    = 31;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [OP_W-1:0] {
        OP_SEQ      = 4'd0,
        OP_BR_EQ    = 4'd1,
        OP_BR_NE    = 4'd2,
        OP_BR_GTZ   = 4'd3,
        OP_BR_GEZ   = 4'd4,
        OP_BR_LTZ   = 4'd5,
        OP_BR_LEZ   = 4'd6,
        OP_JMP_ABS  = 4'd8,
        OP_JMP_REG  = 4'd9,
        OP_CALL_ABS = 4'd10,
        OP_CALL_REG = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        SRC_SEQ,
        SRC_BRANCH,
        SRC_ABS,
        SRC_RIND
    } src_e;

    typedef struct packed {
        word_t seq;
        word_t branch;
        word_t abs;
        word_t rind;
    } targets_t;

    typedef struct packed {
        logic  we;
        ridx_t idx;
        word_t data;
    } link_t;

    function automatic word_t word_offset(input logic [IMM_W-1:0] imm);
        word_t ext;
        ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        return ext << ALIGN_W;
    endfunction

    function automatic logic is_call(input logic [OP_W-1:0] code);
        return (code == OP_CALL_ABS) || (code == OP_CALL_REG);
    endfunction

endpackage

// File: rtl/npc_decide.sv
module npc_decide
    import npc_pkg::*;
(
    input  logic [OP_W-1:0] op_sel,
    input  word_t           rs_val,
    input  word_t           rt_val,
    output logic            taken,
    output src_e            src
);

    logic rs_neg;
    logic rs_zero;
    logic ops_equal;
    logic cond_ok;

    assign rs_neg    = rs_val[XLEN-1];
    assign rs_zero   = (rs_val == '0);
    assign ops_equal = (rs_val == rt_val);

    always_comb begin
        cond_ok = 1'b0;
        src     = SRC_SEQ;
        case (op_sel)
            OP_BR_EQ:   begin cond_ok = ops_equal;          src = SRC_BRANCH; end
            OP_BR_NE:   begin cond_ok = !ops_equal;         src = SRC_BRANCH; end
            OP_BR_GTZ:  begin cond_ok = !rs_neg && !rs_zero; src = SRC_BRANCH; end
            OP_BR_GEZ:  begin cond_ok = !rs_neg;            src = SRC_BRANCH; end
            OP_BR_LTZ:  begin cond_ok = rs_neg;             src = SRC_BRANCH; end
            OP_BR_LEZ:  begin cond_ok = rs_neg || rs_zero;  src = SRC_BRANCH; end
            OP_JMP_ABS,
            OP_CALL_ABS: begin cond_ok = 1'b1;              src = SRC_ABS;    end
            OP_JMP_REG,
            OP_CALL_REG: begin cond_ok = 1'b1;              src = SRC_RIND;   end
            default:    begin cond_ok = 1'b0;               src = SRC_SEQ;    end
        endcase
        if (!cond_ok) begin
            src = SRC_SEQ;
        end
    end

    assign taken = cond_ok;

endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
(
    input  word_t             pc_in,
    input  word_t             rs_val,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [IDX_W-1:0]  jidx,
    output targets_t          tgt
);

    word_t pc4;

    assign pc4        = pc_in + word_t'(INSN_BYTES);
    assign tgt.seq    = pc4;
    assign tgt.branch = pc4 + word_offset(imm16);
    assign tgt.abs    = {pc4[XLEN-1 -: SEG_W], jidx, {ALIGN_W{1'b0}}};
    assign tgt.rind   = rs_val;

endmodule

// File: rtl/npc_link.sv
module npc_link
    import npc_pkg::*;
(
    input  logic [OP_W-1:0] op_sel,
    input  ridx_t           link_rd,
    input  word_t           ret_addr,
    output link_t           lnk
);

    ridx_t dest;

    assign dest     = (op_sel == OP_CALL_ABS) ? ridx_t'(RET_REG) : link_rd;
    assign lnk.idx  = dest;
    assign lnk.data = ret_addr;
    assign lnk.we   = is_call(op_sel) && (dest != '0);

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter bit USE_PC_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [31:0]       pc_in,
    input  logic [3:0]        op_sel,
    input  logic [31:0]       rs_val,
    input  logic [31:0]       rt_val,
    input  logic [15:0]       imm16,
    input  logic [25:0]       jidx,
    input  logic [4:0]        link_rd,
    output logic [31:0]       pc_next,
    output logic              taken,
    output logic              link_we,
    output logic [4:0]        link_idx,
    output logic [31:0]       link_data,
    output logic [31:0]       pc_q
);

    src_e     src;
    targets_t tgt;
    link_t    lnk;

    npc_decide u_decide (
        .op_sel (op_sel),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .taken  (taken),
        .src    (src)
    );

    npc_targets u_targets (
        .pc_in  (pc_in),
        .rs_val (rs_val),
        .imm16  (imm16),
        .jidx   (jidx),
        .tgt    (tgt)
    );

    npc_link u_link (
        .op_sel   (op_sel),
        .link_rd  (link_rd),
        .ret_addr (tgt.seq),
        .lnk      (lnk)
    );

    always_comb begin
        case (src)
            SRC_BRANCH: pc_next = tgt.branch;
            SRC_ABS:    pc_next = tgt.abs;
            SRC_RIND:   pc_next = tgt.rind;
            default:    pc_next = tgt.seq;
        endcase
    end

    assign link_we   = lnk.we;
    assign link_idx  = lnk.idx;
    assign link_data = lnk.data;

    generate
        if (USE_PC_REG) begin : g_pc_reg
            word_t pc_r;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pc_r <= '0;
                end else if (step) begin
                    pc_r <= pc_next;
                end
            end
            assign pc_q = pc_r;
        end else begin : g_no_pc_reg
            assign pc_q = '0;
        end
    endgenerate

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter bit HAS_REG = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        step,
    input logic [31:0] pc_in,
    input logic [3:0]  op_sel,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [25:0] jidx,
    input logic [31:0] pc_next,
    input logic        taken,
    input logic        link_we,
    input logic [4:0]  link_idx,
    input logic [31:0] link_data,
    input logic [31:0] pc_q
);

    logic [31:0] seq_addr;
    logic        quiet_code;
    assign seq_addr   = pc_in + 32'd4;
    assign quiet_code = (op_sel == 4'd0) || (op_sel == 4'd7) || (op_sel >= 4'd12);

    a_r1_quiet_code: assert property (@(posedge clk) disable iff (rst)
        quiet_code |-> (!taken && pc_next == seq_addr));

    a_r2_equal_branch: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'd1) |-> (taken == (rs_val == rt_val)));

    a_r5_abs_target: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'd8 || op_sel == 4'd10) |->
            (taken && pc_next[27:2] == jidx && pc_next[1:0] == 2'b00
                   && pc_next[31:28] == seq_addr[31:28]));

    a_r6_reg_target: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'd9 || op_sel == 4'd11) |-> (taken && pc_next == rs_val));

    a_r7_link_ops: assert property (@(posedge clk) disable iff (rst)
        link_we |-> ((op_sel == 4'd10 || op_sel == 4'd11) && link_idx != 5'd0));

    a_r8_link_data: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_data == seq_addr));

    a_r9_not_taken_seq: assert property (@(posedge clk) disable iff (rst)
        !taken |-> (pc_next == seq_addr));

    generate
        if (HAS_REG) begin : g_reg_chk
            a_r10_reset_value: assert property (@(posedge clk)
                rst |=> (pc_q == 32'd0));

            a_r11_load: assert property (@(posedge clk) disable iff (rst)
                step |=> (pc_q == $past(pc_next)));

            a_r11_hold: assert property (@(posedge clk) disable iff (rst)
                !step |=> $stable(pc_q));
        end
    endgenerate

endmodule

bind npc_unit npc_unit_chk #(.HAS_REG(USE_PC_REG)) u_npc_chk (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .pc_in     (pc_in),
    .op_sel    (op_sel),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .jidx      (jidx),
    .pc_next   (pc_next),
    .taken     (taken),
    .link_we   (link_we),
    .link_idx  (link_idx),
    .link_data (link_data),
    .pc_q      (pc_q)
);

// File: tb/tb_npc_unit.sv
module tb_npc_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic [31:0] pc_in = '0;
    logic [3:0]  op_sel = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [15:0] imm16 = '0;
    logic [25:0] jidx = '0;
    logic [4:0]  link_rd = '0;
    logic [31:0] pc_next;
    logic        taken;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;
    logic [31:0] pc_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    npc_unit dut (
        .clk(clk), .rst(rst), .step(step), .pc_in(pc_in), .op_sel(op_sel),
        .rs_val(rs_val), .rt_val(rt_val), .imm16(imm16), .jidx(jidx),
        .link_rd(link_rd), .pc_next(pc_next), .taken(taken), .link_we(link_we),
        .link_idx(link_idx), .link_data(link_data), .pc_q(pc_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: op=%0d pc=%h rs=%h rt=%h imm=%h actual=%h expected=%h",
                     req, op_sel, pc_in, rs_val, rt_val, imm16, act, exp);
        end
    endtask

    // Reference model written from the requirements
    task automatic model(input int op, input logic [31:0] pc, input logic [31:0] rs,
                         input logic [31:0] rt, input logic [15:0] imm,
                         input logic [25:0] idx, input logic [4:0] rd,
                         output logic [31:0] e_next, output logic e_tak,
                         output logic e_we, output logic [4:0] e_idx,
                         output logic [31:0] e_data);
        logic [31:0] pc4;
        int          off;
        logic        cond;
        pc4  = pc + 32'd4;
        off  = $signed(imm);
        off  = off * 4;
        cond = 1'b0;
        e_next = pc4;
        e_tak  = 1'b0;
        e_we   = 1'b0;
        e_idx  = 5'd0;
        e_data = pc4;
        case (op)
            1: cond = (rs == rt);
            2: cond = (rs != rt);
            3: cond = ($signed(rs) > 0);
            4: cond = ($signed(rs) >= 0);
            5: cond = ($signed(rs) < 0);
            6: cond = ($signed(rs) <= 0);
            default: cond = 1'b0;
        endcase
        if (op >= 1 && op <= 6 && cond) begin
            e_next = pc4 + 32'(off);
            e_tak  = 1'b1;
        end
        if (op == 8 || op == 10) begin
            e_next = (pc4 & 32'hF000_0000) | (32'(idx) * 32'd4);
            e_tak  = 1'b1;
        end
        if (op == 9 || op == 11) begin
            e_next = rs;
            e_tak  = 1'b1;
        end
        if (op == 10) begin
            e_we  = 1'b1;
            e_idx = 5'd31;
        end
        if (op == 11) begin
            e_idx = rd;
            e_we  = (rd != 5'd0);
        end
    endtask

    function automatic string next_tag(input int op);
        if (op >= 1 && op <= 6) return "R4";
        if (op == 8 || op == 10) return "R5";
        if (op == 9 || op == 11) return "R6";
        return "R1";
    endfunction

    function automatic string taken_tag(input int op);
        if (op == 1 || op == 2) return "R2";
        if (op >= 3 && op <= 6) return "R3";
        return "R9";
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        logic [31:0] pcs  [3];
        logic [31:0] rss  [6];
        logic [15:0] imms [2];
        logic [4:0]  rds  [2];
        logic [31:0] e_next, e_data;
        logic        e_tak, e_we;
        logic [4:0]  e_idx;

        pcs  = '{32'h0040_0000, 32'h0FFF_FFFC, 32'hFFFF_FFFC};
        rss  = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h1234_5678};
        imms = '{16'h0010, 16'hFFF0};
        rds  = '{5'd0, 5'd7};

        // R10: synchronous reset clears the PC register
        repeat (2) @(posedge clk);
        #1;
        check("R10", pc_q, 32'h0);

        // Combinational sweep: R1..R9
        for (int o = 0; o < 16; o++) begin
            for (int p = 0; p < 3; p++) begin
                for (int r = 0; r < 6; r++) begin
                    for (int t = 0; t < 2; t++) begin
                        for (int i = 0; i < 2; i++) begin
                            for (int d = 0; d < 2; d++) begin
                                op_sel  = 4'(o);
                                pc_in   = pcs[p];
                                rs_val  = rss[r];
                                rt_val  = (t == 0) ? rss[r] : (rss[r] ^ 32'h0000_0100);
                                imm16   = imms[i];
                                jidx    = 26'h2AB_CDEF ^ 26'(r);
                                link_rd = rds[d];
                                #1;
                                model(o, pc_in, rs_val, rt_val, imm16, jidx, link_rd,
                                      e_next, e_tak, e_we, e_idx, e_data);
                                check(next_tag(o), pc_next, e_next);
                                check(taken_tag(o), 32'(taken), 32'(e_tak));
                                check("R7", 32'(link_we), 32'(e_we));
                                if (e_we) begin
                                    check("R8", 32'(link_idx), 32'(e_idx));
                                    check("R8", link_data, e_data);
                                end
                                if (!e_tak) begin
                                    check("R9", pc_next, pc_in + 32'd4);
                                end
                            end
                        end
                    end
                end
            end
        end

        // R11: PC register loads on step, holds otherwise
        @(negedge clk);
        rst     = 1'b0;
        step    = 1'b1;
        op_sel  = 4'd9;
        rs_val  = 32'h0000_1000;
        pc_in   = 32'h0;
        @(posedge clk);
        #1;
        check("R11", pc_q, 32'h0000_1000);

        @(negedge clk);
        pc_in  = pc_q;
        op_sel = 4'd0;
        @(posedge clk);
        #1;
        check("R11", pc_q, 32'h0000_1004);

        @(negedge clk);
        pc_in  = pc_q;
        step   = 1'b0;
        op_sel = 4'd8;
        jidx   = 26'h000_0100;
        @(posedge clk);
        @(posedge clk);
        #1;
        check("R11", pc_q, 32'h0000_1004);

        @(negedge clk);
        step   = 1'b1;
        op_sel = 4'd5;
        rs_val = 32'hFFFF_FFFE;
        imm16  = 16'hFFFE;
        @(posedge clk);
        #1;
        check("R11", pc_q, 32'h0000_1000);

        // R10: reset again after activity
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R10", pc_q, 32'h0);

        finish_run();
    end

    initial begin
        #1000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

endmodule